// File: doc/BRIEF.md
# Multiplexed Display Word Fetch Master

A read-only bus master on one 16-bit bus that carries first an address and then data. When the display pipeline asks for a word, the block runs a three-clock bus cycle. In the first clock it drives the word address with an address strobe, so that an external transparent latch captures the address. In the second clock it releases the bus and raises the upper-byte and lower-byte data strobes together. In the third clock the memory drives the word onto the bus. At the end of that clock the block samples the word, drops every strobe, and hands the 16-bit word back to the pipeline with a one-cycle valid pulse.

The read/write line is always driven to read. One request can wait while a cycle is running. A waiting request starts the cycle right after the current one, so a steady stream gives one word every three clocks.

Top module: `mux_fetch_master`

## Requirements
- R1: While reset is active and in the first cycle after it, `as_o`, `bus_oe_o`, `uds_o`, `lds_o` and `rvalid_o` are low.
- R2: The first clock of a bus cycle has `as_o` and `bus_oe_o` high, `bus_o` equal to the requested address, and both data strobes low. A request sampled on an idle block starts this phase in the next cycle.
- R3: The clock after the address phase has `as_o` and `bus_oe_o` low and `uds_o` and `lds_o` high. The strobes stay high through the third clock.
- R4: `uds_o` and `lds_o` are equal in every cycle.
- R5: `rw_o` is high (read) in every cycle.
- R6: `bus_oe_o` and the data strobes are never high in the same cycle.
- R7: `bus_i` is sampled at the clock edge that ends the third clock of a cycle. In the following cycle `rvalid_o` is high for one clock, with `rdata_o` equal to that word (bits 15:8 upper byte, bits 7:0 lower byte), and the strobes are low.
- R8: A cycle lasts exactly three clocks. When a request is waiting, the next address phase follows the third clock with no gap, so results come out three clocks apart.
- R9: A request sampled while a cycle runs is held in a single waiting slot and is served after that cycle. A request sampled in the third clock of a cycle while the slot is full refills the slot as the held request launches.
- R10: A request sampled while a cycle runs, the slot is full and the cycle is not in its third clock is discarded and produces no result.
- R11: With no request active or waiting, the block stays idle with all strobes and `bus_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Fetch request, sampled each clock |
| req_addr_i | input | 16 | Word address of the request |
| bus_o | output | 16 | Address driven onto the shared bus |
| bus_oe_o | output | 1 | Bus output enable for the address |
| bus_i | input | 16 | Data read from the shared bus |
| as_o | output | 1 | Address strobe for the external latch |
| uds_o | output | 1 | Upper byte data strobe |
| lds_o | output | 1 | Lower byte data strobe |
| rw_o | output | 1 | Read/write line, always high (read) |
| rdata_o | output | 16 | Fetched display word |
| rvalid_o | output | 1 | One-cycle pulse marking `rdata_o` valid |

## Verification
The first pattern is a single request on an idle block, with each phase checked clock by clock. It separates the address, strobe and sample phases and catches a phase that is off by one. A second request during the address phase and a third during the strobe phase show holding apart from dropping. A request in the third clock while the slot is full tests the refill, and the gap-free three-clock spacing is measured on it. The memory returns a word with its bytes swapped relative to the address. Addresses such as all-zeros, all-ones and mixed-byte values therefore expose swapped halves and stuck bits. The memory model also drives a marker value outside the read window, which makes a sample taken in the wrong clock visible.

// File: rtl/mux_fetch_master.sv
module mux_fetch_master #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic [W-1:0] req_addr_i,
  output logic [W-1:0] bus_o,
  output logic         bus_oe_o,
  input  logic [W-1:0] bus_i,
  output logic         as_o,
  output logic         uds_o,
  output logic         lds_o,
  output logic         rw_o,
  output logic [W-1:0] rdata_o,
  output logic         rvalid_o
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SAMP} phase_t;

  phase_t       ph;
  logic [W-1:0] cur_a, pend_a;
  logic         pend_v;

  wire free   = (ph == S_IDLE) || (ph == S_SAMP);
  wire launch = free && (pend_v || req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= S_IDLE;
      cur_a    <= '0;
      pend_a   <= '0;
      pend_v   <= 1'b0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= 1'b0;
      case (ph)
        S_ADDR:  ph <= S_DATA;
        S_DATA:  ph <= S_SAMP;
        default: ph <= launch ? S_ADDR : S_IDLE;
      endcase
      if (ph == S_SAMP) begin
        rdata_o  <= bus_i;
        rvalid_o <= 1'b1;
      end
      if (launch) cur_a <= pend_v ? pend_a : req_addr_i;
      if (launch && pend_v) begin
        pend_v <= req_i;
        if (req_i) pend_a <= req_addr_i;
      end else if (!launch && req_i && !pend_v) begin
        pend_v <= 1'b1;
        pend_a <= req_addr_i;
      end
    end
  end

  assign as_o     = (ph == S_ADDR);
  assign bus_oe_o = (ph == S_ADDR);
  assign bus_o    = bus_oe_o ? cur_a : '0;
  assign uds_o    = (ph == S_DATA) || (ph == S_SAMP);
  assign lds_o    = uds_o;
  assign rw_o     = 1'b1;

  p_as_then_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    as_o |=> (uds_o && lds_o && !as_o && !bus_oe_o));
  p_addr_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    as_o |-> (bus_oe_o && !uds_o && !lds_o));
  p_strobes_paired_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uds_o == lds_o);
  p_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rw_o);
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe_o && (uds_o || lds_o)));
  p_valid_after_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uds_o) |-> rvalid_o);
  p_three_clock_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uds_o) |=> uds_o ##1 !uds_o);
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> !rvalid_o);

endmodule

// File: tb/tb_mux_fetch_master.sv
module tb_mux_fetch_master;
  logic        clk = 0, rst_n = 0, req = 0;
  logic [15:0] req_addr = '0, bus_o, bus_i, rdata, lat = '0;
  logic        oe, as_s, uds, lds, rw, rvalid;
  int          checks = 0, fails = 0, cyc = 0, last_v = 0, nvalid = 0;
  bit          done = 0;
  logic [15:0] exp_q[$];
  int          stamp_q[$];

  always #5 clk = ~clk;

  mux_fetch_master dut (.clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(req_addr),
    .bus_o(bus_o), .bus_oe_o(oe), .bus_i(bus_i), .as_o(as_s), .uds_o(uds), .lds_o(lds),
    .rw_o(rw), .rdata_o(rdata), .rvalid_o(rvalid));

  function automatic logic [15:0] mem(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  always @(posedge clk) if (as_s) lat <= bus_o;
  assign bus_i = (uds && lds && !oe) ? mem(lat) : 16'hDEAD;

  task automatic chk(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cyc++;
    chk(uds == lds, "R4", {15'd0, uds}, {15'd0, lds});
    chk(rw == 1'b1, "R5", {15'd0, rw}, 16'd1);
    chk(!(oe && uds), "R6", {15'd0, oe}, 16'd0);
    if (rvalid) begin
      nvalid++;
      stamp_q.push_back(cyc);
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected result", rdata, 16'hxxxx);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rdata == e, "R7 data", rdata, e);
      end
    end
  end

  task automatic issue(input logic [15:0] a, input bit expect_it);
    req = 1; req_addr = a;
    if (expect_it) exp_q.push_back(mem(a));
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2);
    chk(!as_s && !oe && !uds && !lds && !rvalid, "R1 in reset", {11'd0, as_s, oe, uds, lds, rvalid}, 16'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!as_s && !oe && !uds && !lds && !rvalid, "R1 after reset", {11'd0, as_s, oe, uds, lds, rvalid}, 16'd0);

    // single fetch, phase by phase
    issue(16'h1234, 1);
    chk(as_s && oe, "R2 strobe/oe", {14'd0, as_s, oe}, 16'd3);
    chk(bus_o == 16'h1234, "R2 address", bus_o, 16'h1234);
    chk(!uds, "R2 no ds", {15'd0, uds}, 16'd0);
    @(negedge clk);
    chk(!as_s && !oe && uds && lds, "R3 clock2", {12'd0, as_s, oe, uds, lds}, 16'd3);
    @(negedge clk);
    chk(uds && !rvalid, "R3 clock3", {14'd0, uds, rvalid}, 16'd2);
    @(negedge clk);
    chk(rvalid && !uds, "R7 valid", {14'd0, rvalid, uds}, 16'd2);
    @(negedge clk);
    chk(!rvalid && !as_s && !uds && !oe, "R11 idle", {12'd0, rvalid, as_s, uds, oe}, 16'd0);
    idle(3);
    chk(!as_s && !uds, "R11 stays idle", {14'd0, as_s, uds}, 16'd0);

    // held then dropped request
    nvalid = 0;
    issue(16'hFFFF, 1);
    issue(16'h0000, 1);   // R9 held
    issue(16'hBEEF, 0);   // R10 dropped (slot full, strobe phase)
    idle(12);
    chk(nvalid == 2, "R10 result count", nvalid[15:0], 16'd2);
    chk(exp_q.size() == 0, "R9 held served", exp_q.size(), 16'd0);

    // refill in the third clock, gap-free stream
    stamp_q.delete();
    issue(16'h8001, 1);
    issue(16'h00FF, 1);
    @(negedge clk);
    issue(16'h7E81, 1);   // third clock of the first cycle, R9 refill
    idle(12);
    chk(stamp_q.size() == 3, "R9 refill count", stamp_q.size(), 16'd3);
    if (stamp_q.size() == 3) begin
      chk(stamp_q[1] - stamp_q[0] == 3, "R8 spacing 1", 16'(stamp_q[1] - stamp_q[0]), 16'd3);
      chk(stamp_q[2] - stamp_q[1] == 3, "R8 spacing 2", 16'(stamp_q[2] - stamp_q[1]), 16'd3);
    end
    chk(exp_q.size() == 0, "R7 all returned", exp_q.size(), 16'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule